// File: doc/BRIEF.md
# Transmit Packet Framer

The framer turns one outgoing packet into a stream of bytes. On a start request it sends a run of preamble bytes, then a sync word, then an optional header, then an optional length byte, then the payload bytes that the host supplies, and finally an optional two-byte CRC. All fields except the payload come from configuration inputs. The host only delivers payload bytes through a ready/valid input, and the downstream serializer takes bytes through a ready/valid output.

Configuration is copied into internal registers when a start request is accepted, so it may change freely while a frame is in flight. Each field has its own programmable length. The header may be empty, and the length byte and the CRC can each be switched off. The CRC runs over the header, the length byte and the payload, using one of two 16-bit polynomials. A one-cycle done pulse marks the end of every frame.

Top module: `pkt_tx_framer`

## Requirements
- R1: A frame is sent in this fixed order: preamble, sync, header, length byte, payload, CRC. Absent fields are skipped with no gap. Outside the payload, `tx_valid_o` stays high from the first byte to the last byte of the frame.
- R2: The preamble is `pre_len_m1_i`+1 bytes long (1 to 512), and every preamble byte is 0xAA.
- R3: The sync field is `sync_len_m1_i`+1 bytes long (1 to 4). It carries the low N bytes of `sync_word_i`, most significant of those bytes first.
- R4: The header is `hdr_len_i` bytes long (0 to 4). It carries the low N bytes of `hdr_word_i`, most significant first. A length of 0 omits the header.
- R5: When `len_en_i` is 1, a single byte equal to `pay_len_i` follows the header. When `len_en_i` is 0, no length byte is sent.
- R6: During the payload, exactly `pay_len_i` bytes (1 to 255) pass from `pay_data_i` to `tx_data_o`, with `tx_valid_o` = `pay_valid_i` and `pay_ready_o` = `tx_ready_i`. At all other times `pay_ready_o` is 0.
- R7: When `crc_en_i` is 1, two CRC bytes are sent, high byte first. `crc_sel_i`=0 selects polynomial 0x1021 and 1 selects 0x8005. The CRC is seeded with 0xFFFF, processes bits MSB first, has no reflection and no final XOR, and covers the header, the length byte and the payload.
- R8: While `tx_valid_o` is high and `tx_ready_i` is low outside the payload, `tx_data_o` holds its value.
- R9: A start request while a frame is in progress is ignored.
- R10: `done_o` is high for exactly one cycle, in the cycle after the last byte of the frame is accepted.
- R11: After reset, and whenever no frame is in progress, `tx_valid_o`, `pay_ready_o` and `done_o` are 0.
- R12: Configuration is sampled when a start request is accepted. Later changes to it do not affect the frame in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request for a new frame |
| pre_len_m1_i | input | 9 | Preamble byte count minus one |
| sync_len_m1_i | input | 2 | Sync byte count minus one |
| sync_word_i | input | 32 | Sync value, low bytes used |
| hdr_len_i | input | 3 | Header byte count, 0 to 4 |
| hdr_word_i | input | 32 | Header value, low bytes used |
| len_en_i | input | 1 | Send the length byte |
| pay_len_i | input | 8 | Payload byte count, 1 to 255 |
| crc_en_i | input | 1 | Append the CRC |
| crc_sel_i | input | 1 | CRC polynomial: 0 = 0x1021, 1 = 0x8005 |
| pay_data_i | input | 8 | Payload byte from the host |
| pay_valid_i | input | 1 | Payload byte valid |
| pay_ready_o | output | 1 | Framer accepts the payload byte |
| tx_data_o | output | 8 | Outgoing byte |
| tx_valid_o | output | 1 | Outgoing byte valid |
| tx_ready_i | input | 1 | Downstream accepts the byte |
| done_o | output | 1 | One-cycle end-of-frame pulse |

## Verification
The frames under test range from the smallest possible frame (one preamble byte, one sync byte, no header, no length byte, no CRC, one payload byte) to a frame with 512 preamble bytes and 255 payload bytes. The minimal frame exposes mistakes in skipping fields and in first/last byte handling. The long frame exercises the full width of the counters. Frames that use both polynomials, different header and sync widths, and length byte or CRC switched on and off separate errors in byte ordering from errors in CRC coverage. Back-pressure and gaps in the payload source are applied in distinct rhythms to expose stall and pass-through faults. One frame is hit mid-flight with a start request and with changed configuration, which shows whether configuration is captured at start or read live.

// File: rtl/pkt_fr_pkg.sv
// Shared types and constants for the transmit packet framer.
package pkt_fr_pkg;

    // Field currently being sent; FLD_IDLE means no frame in flight.
    typedef enum logic [2:0] {
        FLD_IDLE = 3'd0,
        FLD_PRE  = 3'd1,
        FLD_SYNC = 3'd2,
        FLD_HDR  = 3'd3,
        FLD_LEN  = 3'd4,
        FLD_PAY  = 3'd5,
        FLD_CRC  = 3'd6
    } fld_e;

    localparam logic [15:0] POLY_CCITT = 16'h1021;
    localparam logic [15:0] POLY_IBM   = 16'h8005;
    localparam logic [15:0] CRC_SEED   = 16'hFFFF;
    localparam logic [7:0]  PRE_BYTE   = 8'hAA;

endpackage

// File: rtl/pkt_fr_cfg.sv
// Configuration capture: copies every frame setting into registers when a
// start request is accepted, so the frame in flight never sees later changes.
// Assumes the caller raises go only while idle.
module pkt_fr_cfg #(
    parameter int PRE_CNT_W  = 9,
    parameter int SYNC_LEN_W = 2,
    parameter int SYNC_W     = 32,
    parameter int HDR_LEN_W  = 3,
    parameter int HDR_W      = 32,
    parameter int PAY_CNT_W  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  go,
    input  logic [PRE_CNT_W-1:0]  pre_len_m1_d,
    input  logic [SYNC_LEN_W-1:0] sync_len_m1_d,
    input  logic [SYNC_W-1:0]     sync_word_d,
    input  logic [HDR_LEN_W-1:0]  hdr_len_d,
    input  logic [HDR_W-1:0]      hdr_word_d,
    input  logic                  len_en_d,
    input  logic [PAY_CNT_W-1:0]  pay_len_d,
    input  logic                  crc_en_d,
    input  logic                  crc_sel_d,
    output logic [PRE_CNT_W-1:0]  pre_len_m1_q,
    output logic [SYNC_LEN_W-1:0] sync_len_m1_q,
    output logic [SYNC_W-1:0]     sync_word_q,
    output logic [HDR_LEN_W-1:0]  hdr_len_q,
    output logic [HDR_W-1:0]      hdr_word_q,
    output logic                  len_en_q,
    output logic [PAY_CNT_W-1:0]  pay_len_q,
    output logic                  crc_en_q,
    output logic                  crc_sel_q
);

    // Capture the settings on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_len_m1_q  <= '0;
            sync_len_m1_q <= '0;
            sync_word_q   <= '0;
            hdr_len_q     <= '0;
            hdr_word_q    <= '0;
            len_en_q      <= 1'b0;
            pay_len_q     <= '0;
            crc_en_q      <= 1'b0;
            crc_sel_q     <= 1'b0;
        end else if (go) begin
            pre_len_m1_q  <= pre_len_m1_d;
            sync_len_m1_q <= sync_len_m1_d;
            sync_word_q   <= sync_word_d;
            hdr_len_q     <= hdr_len_d;
            hdr_word_q    <= hdr_word_d;
            len_en_q      <= len_en_d;
            pay_len_q     <= pay_len_d;
            crc_en_q      <= crc_en_d;
            crc_sel_q     <= crc_sel_d;
        end
    end

endmodule

// File: rtl/pkt_fr_seq.sv
// Field sequencer: tracks which field is being sent and the byte index inside
// it, moves to the next present field after the last byte is accepted, and
// pulses done one cycle after the frame's final byte. Assumes a header
// length no larger than the header register and a payload length of at least 1.
module pkt_fr_seq
    import pkt_fr_pkg::*;
#(
    parameter int PRE_CNT_W  = 9,
    parameter int SYNC_LEN_W = 2,
    parameter int HDR_LEN_W  = 3,
    parameter int PAY_CNT_W  = 8,
    parameter int IDX_W      = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  beat,
    input  logic [PRE_CNT_W-1:0]  pre_len_m1,
    input  logic [SYNC_LEN_W-1:0] sync_len_m1,
    input  logic [HDR_LEN_W-1:0]  hdr_len,
    input  logic                  len_en,
    input  logic [PAY_CNT_W-1:0]  pay_len,
    input  logic                  crc_en,
    output logic                  go,
    output fld_e                  fld_q,
    output logic [IDX_W-1:0]      idx_q,
    output logic                  done_q
);

    logic [IDX_W-1:0] last_idx;
    fld_e             fld_nxt;

    assign go = start && (fld_q == FLD_IDLE);

    // Index of the final byte of the current field.
    always_comb begin
        case (fld_q)
            FLD_PRE:  last_idx = IDX_W'(pre_len_m1);
            FLD_SYNC: last_idx = IDX_W'(sync_len_m1);
            FLD_HDR:  last_idx = IDX_W'(hdr_len) - IDX_W'(1);
            FLD_PAY:  last_idx = IDX_W'(pay_len) - IDX_W'(1);
            FLD_CRC:  last_idx = IDX_W'(1);
            default:  last_idx = '0;
        endcase
    end

    // Field that follows the current one, skipping absent fields.
    always_comb begin
        case (fld_q)
            FLD_PRE:  fld_nxt = FLD_SYNC;
            FLD_SYNC: fld_nxt = (hdr_len != '0) ? FLD_HDR :
                                (len_en ? FLD_LEN : FLD_PAY);
            FLD_HDR:  fld_nxt = len_en ? FLD_LEN : FLD_PAY;
            FLD_LEN:  fld_nxt = FLD_PAY;
            FLD_PAY:  fld_nxt = crc_en ? FLD_CRC : FLD_IDLE;
            default:  fld_nxt = FLD_IDLE;
        endcase
    end

    // Advance field and byte index on accepted bytes; raise done at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fld_q  <= FLD_IDLE;
            idx_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (fld_q == FLD_IDLE) begin
                if (start) begin
                    fld_q <= FLD_PRE;
                    idx_q <= '0;
                end
            end else if (beat) begin
                if (idx_q == last_idx) begin
                    fld_q  <= fld_nxt;
                    idx_q  <= '0;
                    done_q <= (fld_nxt == FLD_IDLE);
                end else begin
                    idx_q <= idx_q + IDX_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/pkt_fr_crc.sv
// CRC-16 accumulator: processes one byte per update, MSB first, with no
// reflection and no final XOR. The polynomial is chosen by sel. Assumes
// clear and upd are never high together.
module pkt_fr_crc
    import pkt_fr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        upd,
    input  logic        sel,
    input  logic [7:0]  data,
    output logic [15:0] crc_q
);

    logic [15:0] poly;
    logic [15:0] crc_nxt;

    assign poly = sel ? POLY_IBM : POLY_CCITT;

    // Fold one byte into the running remainder, bit by bit.
    always_comb begin
        crc_nxt = crc_q;
        for (int b = 7; b >= 0; b--) begin
            if (crc_nxt[15] ^ data[b]) begin
                crc_nxt = {crc_nxt[14:0], 1'b0} ^ poly;
            end else begin
                crc_nxt = {crc_nxt[14:0], 1'b0};
            end
        end
    end

    // Hold the remainder: seed on clear, fold on update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= CRC_SEED;
        end else if (clear) begin
            crc_q <= CRC_SEED;
        end else if (upd) begin
            crc_q <= crc_nxt;
        end
    end

endmodule

// File: rtl/pkt_tx_framer.sv
// Transmit packet framer top: captures the configuration at start, steps
// through the fields, picks the outgoing byte and passes payload bytes
// straight through under the downstream handshake. Assumes the payload
// source holds its byte while valid and not ready.
module pkt_tx_framer
    import pkt_fr_pkg::*;
#(
    parameter int PRE_CNT_W  = 9,
    parameter int SYNC_BYTES = 4,
    parameter int HDR_BYTES  = 4,
    parameter int PAY_CNT_W  = 8
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 start_i,
    input  logic [PRE_CNT_W-1:0]                 pre_len_m1_i,
    input  logic [$clog2(SYNC_BYTES)-1:0]        sync_len_m1_i,
    input  logic [SYNC_BYTES*8-1:0]              sync_word_i,
    input  logic [$clog2(HDR_BYTES+1)-1:0]       hdr_len_i,
    input  logic [HDR_BYTES*8-1:0]               hdr_word_i,
    input  logic                                 len_en_i,
    input  logic [PAY_CNT_W-1:0]                 pay_len_i,
    input  logic                                 crc_en_i,
    input  logic                                 crc_sel_i,
    input  logic [7:0]                           pay_data_i,
    input  logic                                 pay_valid_i,
    output logic                                 pay_ready_o,
    output logic [7:0]                           tx_data_o,
    output logic                                 tx_valid_o,
    input  logic                                 tx_ready_i,
    output logic                                 done_o
);

    localparam int SYNC_LEN_W = $clog2(SYNC_BYTES);
    localparam int HDR_LEN_W  = $clog2(HDR_BYTES + 1);
    localparam int SYNC_W     = SYNC_BYTES * 8;
    localparam int HDR_W      = HDR_BYTES * 8;
    localparam int IDX_W      = (PRE_CNT_W > PAY_CNT_W) ? PRE_CNT_W : PAY_CNT_W;
    localparam int SYNC_SLOTS = 1 << SYNC_LEN_W;
    localparam int HDR_SLOTS  = 1 << HDR_LEN_W;

    logic [PRE_CNT_W-1:0]  pre_len_m1_q;
    logic [SYNC_LEN_W-1:0] sync_len_m1_q;
    logic [SYNC_W-1:0]     sync_word_q;
    logic [HDR_LEN_W-1:0]  hdr_len_q;
    logic [HDR_W-1:0]      hdr_word_q;
    logic                  len_en_q;
    logic [PAY_CNT_W-1:0]  pay_len_q;
    logic                  crc_en_q;
    logic                  crc_sel_q;

    logic                  go;
    logic                  beat;
    fld_e                  fld_q;
    logic [IDX_W-1:0]      idx_q;
    logic [15:0]           crc_q;
    logic                  crc_upd;

    logic [7:0]            sync_b [SYNC_SLOTS];
    logic [7:0]            hdr_b  [HDR_SLOTS];
    logic [SYNC_LEN_W-1:0] sync_sel;
    logic [HDR_LEN_W-1:0]  hdr_sel;

    pkt_fr_cfg #(
        .PRE_CNT_W (PRE_CNT_W),
        .SYNC_LEN_W(SYNC_LEN_W),
        .SYNC_W    (SYNC_W),
        .HDR_LEN_W (HDR_LEN_W),
        .HDR_W     (HDR_W),
        .PAY_CNT_W (PAY_CNT_W)
    ) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .go           (go),
        .pre_len_m1_d (pre_len_m1_i),
        .sync_len_m1_d(sync_len_m1_i),
        .sync_word_d  (sync_word_i),
        .hdr_len_d    (hdr_len_i),
        .hdr_word_d   (hdr_word_i),
        .len_en_d     (len_en_i),
        .pay_len_d    (pay_len_i),
        .crc_en_d     (crc_en_i),
        .crc_sel_d    (crc_sel_i),
        .pre_len_m1_q (pre_len_m1_q),
        .sync_len_m1_q(sync_len_m1_q),
        .sync_word_q  (sync_word_q),
        .hdr_len_q    (hdr_len_q),
        .hdr_word_q   (hdr_word_q),
        .len_en_q     (len_en_q),
        .pay_len_q    (pay_len_q),
        .crc_en_q     (crc_en_q),
        .crc_sel_q    (crc_sel_q)
    );

    pkt_fr_seq #(
        .PRE_CNT_W (PRE_CNT_W),
        .SYNC_LEN_W(SYNC_LEN_W),
        .HDR_LEN_W (HDR_LEN_W),
        .PAY_CNT_W (PAY_CNT_W),
        .IDX_W     (IDX_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start_i),
        .beat       (beat),
        .pre_len_m1 (pre_len_m1_q),
        .sync_len_m1(sync_len_m1_q),
        .hdr_len    (hdr_len_q),
        .len_en     (len_en_q),
        .pay_len    (pay_len_q),
        .crc_en     (crc_en_q),
        .go         (go),
        .fld_q      (fld_q),
        .idx_q      (idx_q),
        .done_q     (done_o)
    );

    pkt_fr_crc u_crc (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(go),
        .upd  (crc_upd),
        .sel  (crc_sel_q),
        .data (tx_data_o),
        .crc_q(crc_q)
    );

    // Split the sync and header words into byte slots; unused slots read zero.
    for (genvar g = 0; g < SYNC_SLOTS; g++) begin : g_sync_slot
        if (g < SYNC_BYTES) begin : g_used
            assign sync_b[g] = sync_word_q[g*8 +: 8];
        end else begin : g_pad
            assign sync_b[g] = 8'h00;
        end
    end

    for (genvar g = 0; g < HDR_SLOTS; g++) begin : g_hdr_slot
        if (g < HDR_BYTES) begin : g_used
            assign hdr_b[g] = hdr_word_q[g*8 +: 8];
        end else begin : g_pad
            assign hdr_b[g] = 8'h00;
        end
    end

    // Most significant active byte goes first.
    assign sync_sel = sync_len_m1_q - idx_q[SYNC_LEN_W-1:0];
    assign hdr_sel  = hdr_len_q - HDR_LEN_W'(1) - idx_q[HDR_LEN_W-1:0];

    // Handshake and pass-through for the payload.
    assign tx_valid_o  = (fld_q == FLD_PAY) ? pay_valid_i : (fld_q != FLD_IDLE);
    assign pay_ready_o = (fld_q == FLD_PAY) && tx_ready_i;
    assign beat        = tx_valid_o && tx_ready_i;
    assign crc_upd     = beat && ((fld_q == FLD_HDR) || (fld_q == FLD_LEN) ||
                                  (fld_q == FLD_PAY));

    // Select the outgoing byte for the current field.
    always_comb begin
        case (fld_q)
            FLD_PRE:  tx_data_o = PRE_BYTE;
            FLD_SYNC: tx_data_o = sync_b[sync_sel];
            FLD_HDR:  tx_data_o = hdr_b[hdr_sel];
            FLD_LEN:  tx_data_o = 8'(pay_len_q);
            FLD_PAY:  tx_data_o = pay_data_i;
            FLD_CRC:  tx_data_o = (idx_q == '0) ? crc_q[15:8] : crc_q[7:0];
            default:  tx_data_o = 8'h00;
        endcase
    end

endmodule

// File: rtl/pkt_fr_chk.sv
// Assertion checker for the transmit packet framer, bound to the top module.
// Observes the ports plus the sequencer's field and index registers.
module pkt_fr_chk
    import pkt_fr_pkg::*;
#(
    parameter int IDX_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input fld_e             fld,
    input logic [IDX_W-1:0] idx,
    input logic [7:0]       tx_data,
    input logic             tx_valid,
    input logic             tx_ready,
    input logic [7:0]       pay_data,
    input logic             pay_valid,
    input logic             pay_ready,
    input logic             done
);

    // R2: every preamble byte on the output is 0xAA.
    p_pre_pattern_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fld == FLD_PRE) |-> (tx_valid && tx_data == 8'hAA));

    // R6: an accepted payload byte appears unchanged and valid on the output.
    p_pay_through_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pay_ready && pay_valid) |-> (tx_valid && tx_data == pay_data));

    // R8: a stalled non-payload byte is held.
    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fld != FLD_PAY && fld != FLD_IDLE && tx_valid && !tx_ready)
        |=> (tx_valid && $stable(tx_data)));

    // R9: without an accepted byte, a busy framer keeps its position.
    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fld != FLD_IDLE && !(tx_valid && tx_ready))
        |=> ($stable(fld) && $stable(idx)));

    // R10: done lasts one cycle.
    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: done follows an accepted byte.
    p_done_after_beat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(tx_valid && tx_ready));

    // R11: when idle the handshakes are quiet.
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (fld == FLD_IDLE) |-> (!tx_valid && !pay_ready));

endmodule

bind pkt_tx_framer pkt_fr_chk #(.IDX_W(IDX_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fld      (fld_q),
    .idx      (idx_q),
    .tx_data  (tx_data_o),
    .tx_valid (tx_valid_o),
    .tx_ready (tx_ready_i),
    .pay_data (pay_data_i),
    .pay_valid(pay_valid_i),
    .pay_ready(pay_ready_o),
    .done     (done_o)
);

// File: tb/test_pkt_tx_framer.sv
// Self-checking bench: builds the expected byte stream of each frame in
// queues and compares the framer's handshakes and data every clock.
module test_pkt_tx_framer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [8:0]  pre_len_m1_i = '0;
    logic [1:0]  sync_len_m1_i = '0;
    logic [31:0] sync_word_i = '0;
    logic [2:0]  hdr_len_i = '0;
    logic [31:0] hdr_word_i = '0;
    logic        len_en_i = 1'b0;
    logic [7:0]  pay_len_i = '0;
    logic        crc_en_i = 1'b0;
    logic        crc_sel_i = 1'b0;
    logic [7:0]  pay_data_i = '0;
    logic        pay_valid_i = 1'b0;
    logic        pay_ready_o;
    logic [7:0]  tx_data_o;
    logic        tx_valid_o;
    logic        tx_ready_i = 1'b0;
    logic        done_o;

    int checks = 0;
    int errors = 0;

    logic [7:0] exp_q[$];
    int         kind_q[$];
    logic [7:0] pay_q[$];

    always #5 clk = ~clk;

    pkt_tx_framer i_pkt_tx_framer (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .pre_len_m1_i (pre_len_m1_i),
        .sync_len_m1_i(sync_len_m1_i),
        .sync_word_i  (sync_word_i),
        .hdr_len_i    (hdr_len_i),
        .hdr_word_i   (hdr_word_i),
        .len_en_i     (len_en_i),
        .pay_len_i    (pay_len_i),
        .crc_en_i     (crc_en_i),
        .crc_sel_i    (crc_sel_i),
        .pay_data_i   (pay_data_i),
        .pay_valid_i  (pay_valid_i),
        .pay_ready_o  (pay_ready_o),
        .tx_data_o    (tx_data_o),
        .tx_valid_o   (tx_valid_o),
        .tx_ready_i   (tx_ready_i),
        .done_o       (done_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d,
                                             input bit sel);
        logic [15:0] poly = sel ? 16'h8005 : 16'h1021;
        for (int i = 7; i >= 0; i--) begin
            logic fb = c[15] ^ d[i];
            c = {c[14:0], 1'b0};
            if (fb) c = c ^ poly;
        end
        return c;
    endfunction

    function automatic string tag_of(input int k);
        case (k)
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            5: return "R6";
            default: return "R7";
        endcase
    endfunction

    // Runs one frame; mode sets the ready/valid rhythm, poke disturbs it mid-flight.
    task automatic run_frame(input int pre_n, input int sync_n, input logic [31:0] sw,
                             input int hdr_n, input logic [31:0] hw, input bit len_en,
                             input int pay_n, input bit crc_en, input bit sel,
                             input int mode, input bit poke, input int seed);
        logic [15:0] crc = 16'hFFFF;
        int  pidx = 0;
        int  cyc = 0;
        bit  exp_done = 1'b0;
        bit  fin = 1'b0;
        exp_q.delete(); kind_q.delete(); pay_q.delete();
        for (int i = 0; i < pre_n; i++) begin exp_q.push_back(8'hAA); kind_q.push_back(1); end
        for (int i = sync_n - 1; i >= 0; i--) begin
            exp_q.push_back(sw[i*8 +: 8]); kind_q.push_back(2);
        end
        for (int i = hdr_n - 1; i >= 0; i--) begin
            exp_q.push_back(hw[i*8 +: 8]); kind_q.push_back(3);
            crc = crc_step(crc, hw[i*8 +: 8], sel);
        end
        if (len_en) begin
            exp_q.push_back(8'(pay_n)); kind_q.push_back(4);
            crc = crc_step(crc, 8'(pay_n), sel);
        end
        for (int i = 0; i < pay_n; i++) begin
            logic [7:0] b = 8'((i * 37 + seed * 11 + 5) & 8'hFF);
            pay_q.push_back(b); exp_q.push_back(b); kind_q.push_back(5);
            crc = crc_step(crc, b, sel);
        end
        if (crc_en) begin
            exp_q.push_back(crc[15:8]); kind_q.push_back(6);
            exp_q.push_back(crc[7:0]);  kind_q.push_back(6);
        end

        @(posedge clk); #1;
        pre_len_m1_i = 9'(pre_n - 1); sync_len_m1_i = 2'(sync_n - 1); sync_word_i = sw;
        hdr_len_i = 3'(hdr_n); hdr_word_i = hw; len_en_i = len_en; pay_len_i = 8'(pay_n);
        crc_en_i = crc_en; crc_sel_i = sel; start_i = 1'b1;
        tx_ready_i = 1'b1; pay_valid_i = 1'b0;
        @(negedge clk);
        chk(!tx_valid_o && !pay_ready_o, "R11 idle before start", tx_valid_o, 0);
        @(posedge clk); #1;

        while (!fin) begin
            // Drive this cycle's stimulus.
            start_i = poke && (cyc == 5);
            if (poke && cyc == 5) begin
                pre_len_m1_i = 9'd40; sync_word_i = ~sw; hdr_len_i = 3'd1;
                len_en_i = ~len_en; crc_sel_i = ~sel; pay_len_i = 8'd3;
            end
            case (mode)
                1: begin tx_ready_i = (cyc % 3) != 1; pay_valid_i = (cyc % 4) != 2; end
                2: begin tx_ready_i = (cyc % 5) < 3;  pay_valid_i = (cyc % 2) == 0; end
                default: begin tx_ready_i = 1'b1; pay_valid_i = 1'b1; end
            endcase
            pay_data_i = (pidx < pay_q.size()) ? pay_q[pidx] : 8'h00;

            @(negedge clk);
            chk(done_o == exp_done, "R10 done pulse", done_o, exp_done);
            if (exp_done) begin
                fin = 1'b1;
                chk(!tx_valid_o && !pay_ready_o, "R11 idle after frame", tx_valid_o, 0);
            end
            exp_done = 1'b0;
            if (exp_q.size() > 0) begin
                if (kind_q[0] == 5) begin
                    chk(tx_valid_o == pay_valid_i, "R6 valid pass-through", tx_valid_o, pay_valid_i);
                    chk(pay_ready_o == tx_ready_i, "R6 ready pass-through", pay_ready_o, tx_ready_i);
                    if (tx_valid_o)
                        chk(tx_data_o == exp_q[0], "R6 payload byte", tx_data_o, exp_q[0]);
                end else begin
                    chk(tx_valid_o, "R1 byte present", tx_valid_o, 1);
                    chk(!pay_ready_o, "R6 ready outside payload", pay_ready_o, 0);
                    chk(tx_data_o == exp_q[0], tx_ready_i ? tag_of(kind_q[0]) : "R8 stalled byte",
                        tx_data_o, exp_q[0]);
                end
                if (tx_valid_o && tx_ready_i) begin
                    if (kind_q[0] == 5) pidx++;
                    void'(exp_q.pop_front()); void'(kind_q.pop_front());
                    if (exp_q.size() == 0) exp_done = 1'b1;
                end
            end
            cyc++;
            if (cyc > 20000) begin
                chk(1'b0, "R1 watchdog expired", cyc, 0);
                fin = 1'b1;
            end
            @(posedge clk); #1;
        end
        start_i = 1'b0;
        chk(exp_q.size() == 0 && pidx == pay_n, poke ? "R9/R12 frame intact" : "R1 frame complete",
            exp_q.size(), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!tx_valid_o && !pay_ready_o && !done_o, "R11 in reset", tx_valid_o, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!tx_valid_o && !pay_ready_o && !done_o, "R11 after reset", tx_valid_o, 0);

        // Smallest frame: every optional field absent.
        run_frame(1, 1, 32'h0000_002D, 0, 32'h0, 1'b0, 1, 1'b0, 1'b0, 0, 1'b0, 1);
        // Full widths, CCITT, with back-pressure.
        run_frame(4, 4, 32'h2DD4_5A3C, 4, 32'h1122_3344, 1'b1, 10, 1'b1, 1'b0, 1, 1'b0, 2);
        // IBM polynomial, disturbed mid-frame.
        run_frame(3, 2, 32'hAAAA_C3E1, 2, 32'h0000_BEEF, 1'b1, 5, 1'b1, 1'b1, 0, 1'b1, 3);
        // Longest preamble and payload.
        run_frame(512, 3, 32'h0012_3456, 1, 32'h0000_0077, 1'b0, 255, 1'b1, 1'b0, 2, 1'b0, 4);
        // Three header bytes, no length byte, IBM.
        run_frame(2, 1, 32'h0000_0099, 3, 32'h00A1_B2C3, 1'b0, 2, 1'b1, 1'b1, 1, 1'b0, 5);

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!tx_valid_o && !done_o, "R11 idle at end", tx_valid_o, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1500000;
        errors++;
        checks++;
        $display("FAIL R1 global watchdog actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule